// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the raster timing for a cathode-ray display: a horizontal pixel counter, a vertical line counter, a display-window flag, a blanking flag, and two pairs of sync pulses. The first pair drives the monitor. The second pair is an independent copy meant for a flat-panel link. All timing comes from nine registers that software loads through a small write port (address, data, strobe). The block itself has no fixed mode table, so any standard mode, such as 640x480 at 72 Hz or 1280x1024 at 60 Hz, is set up purely by register contents.

Each timing register holds two 11-bit values, each stored as the real count minus one. Software writes a shadow copy. The counters and window logic read a live copy, which takes the shadow contents only at a frame boundary or while timing is stopped, so a mode change never tears a frame. A global enable starts the raster from pixel 0 of line 0 and stops it again. While it is stopped, the syncs rest at their inactive levels.

Top module: `crt_timing_gen`

## Requirements
- R1: After reset both counters read 0, `active` is 0, `blank` is 1 and all four sync outputs are 0, because every register resets to zero, which includes the polarity bits.
- R2: Register word layout: the first value sits in bits 10:0 and the second in bits 26:16. Addresses: 0 = horizontal (active-1, total-1), 1 = horizontal blank (start-1, end-1), 2 = horizontal sync (start-1, end-1), 3 = panel horizontal sync (start-1, end-1), 4 = vertical (active-1, total-1), 5 = vertical blank (start-1, end-1), 6 = vertical sync (start-1, end-1), 7 = panel vertical sync (start-2, end-2), 8 = polarity in bits 1:0.
- R3: While running, `h_count` steps by one each clock and goes from its stored total back to 0. `v_count` steps by one each time `h_count` wraps, and goes from its stored total back to 0.
- R4: While running, `active` is 1 exactly when `h_count` is no greater than the stored horizontal active value and `v_count` is no greater than the stored vertical active value.
- R5: While running, `blank` is 1 when the horizontal count lies above the stored blank start and at or below the stored blank end, or when the vertical count does the same against the vertical blank pair.
- R6: A CRT sync is raw-active while its counter is at or above the stored start and below the stored end. With a start-1/end-1 pair written as 663/703, the pulse covers 40 counts.
- R7: Polarity bit 0 controls both horizontal syncs and bit 1 controls both vertical syncs. A 1 makes that sync active low and a 0 makes it active high. The output equals the raw active state XOR the bit.
- R8: The panel syncs use their own registers (3 and 7) with the same window rule as R6. A panel vertical pair written start-2/end-2 therefore begins one line ahead of the CRT vertical sync.
- R9: A write made while running has no effect on any output until the first pixel of the next frame. A write made while stopped is in effect by the second clock edge after the write.
- R10: When `tmg_en` is low at a clock edge, both counters read 0 after that edge, `active` is 0, `blank` is 1 and every sync sits at its inactive level. The first cycle after `tmg_en` is sampled high again shows pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (R2) |
| wr_data | input | 32 | Register write data |
| tmg_en | input | 1 | Global timing enable |
| h_count | output | 11 | Horizontal pixel counter |
| v_count | output | 11 | Vertical line counter |
| active | output | 1 | Inside the visible display window |
| blank | output | 1 | Blanking interval flag |
| crt_hsync | output | 1 | Monitor horizontal sync |
| crt_vsync | output | 1 | Monitor vertical sync |
| pnl_hsync | output | 1 | Panel horizontal sync |
| pnl_vsync | output | 1 | Panel vertical sync |

## Verification
The assertions assume that software programs every start, end and active value no larger than the matching total, and that register writes arrive one per clock, either while stopped or at most once per frame while running. The bench programs only self-consistent modes. It changes a register mid-frame only after the frame has started, and then lets at least a whole frame pass before the next change. This keeps each counter within its live total, and keeps the live copy frozen except at a frame edge or while stopped.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;

    localparam int FIELD_W = 11;
    localparam int HI_LSB  = 16;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int POL_W   = 2;

    typedef logic [FIELD_W-1:0] tval_t;

    // one register: first value and second value, both stored pre-decremented
    typedef struct packed {
        tval_t lo;
        tval_t hi;
    } pair_t;

    typedef struct packed {
        pair_t act_tot;
        pair_t blank;
        pair_t sync;
        pair_t pnl;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t        h;
        axis_cfg_t        v;
        logic [POL_W-1:0] pol;
    } timing_cfg_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_H_ACT_TOT = 4'd0,
        RA_H_BLANK   = 4'd1,
        RA_H_SYNC    = 4'd2,
        RA_H_PANEL   = 4'd3,
        RA_V_ACT_TOT = 4'd4,
        RA_V_BLANK   = 4'd5,
        RA_V_SYNC    = 4'd6,
        RA_V_PANEL   = 4'd7,
        RA_POLARITY  = 4'd8
    } reg_addr_e;

    function automatic pair_t unpack_pair(input logic [DATA_W-1:0] w);
        pair_t p;
        p.lo = w[FIELD_W-1:0];
        p.hi = w[HI_LSB +: FIELD_W];
        return p;
    endfunction

endpackage

// File: rtl/crt_timing_regs.sv
module crt_timing_regs
    import crt_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output timing_cfg_t       live
);

    typedef struct packed {
        timing_cfg_t shadow;
        timing_cfg_t live;
    } regs_state_t;

    regs_state_t st_d, st_q;

    // bits outside the two packed fields carry nothing
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[DATA_W-1:HI_LSB+FIELD_W],
                              wr_data[HI_LSB-1:FIELD_W]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                RA_H_ACT_TOT: st_d.shadow.h.act_tot = unpack_pair(wr_data);
                RA_H_BLANK:   st_d.shadow.h.blank   = unpack_pair(wr_data);
                RA_H_SYNC:    st_d.shadow.h.sync    = unpack_pair(wr_data);
                RA_H_PANEL:   st_d.shadow.h.pnl     = unpack_pair(wr_data);
                RA_V_ACT_TOT: st_d.shadow.v.act_tot = unpack_pair(wr_data);
                RA_V_BLANK:   st_d.shadow.v.blank   = unpack_pair(wr_data);
                RA_V_SYNC:    st_d.shadow.v.sync    = unpack_pair(wr_data);
                RA_V_PANEL:   st_d.shadow.v.pnl     = unpack_pair(wr_data);
                RA_POLARITY:  st_d.shadow.pol       = wr_data[POL_W-1:0];
                default:      st_d.shadow           = st_q.shadow;
            endcase
        end
        // live copy follows the shadow only at a frame edge or while stopped
        if (load) begin
            st_d.live = st_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live = st_q.live;

    // R9: nothing but a load may change the live timing set
    assert_live_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.live));

endmodule

// File: rtl/crt_axis_counter.sv
module crt_axis_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    logic [W-1:0] cnt_d, cnt_q;
    logic         at_last;

    assign at_last = (cnt_q == last);

    always_comb begin
        cnt_d = cnt_q;
        if (!go) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = at_last ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt  = cnt_q;
    assign wrap = go & step & at_last;

    assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);

    assert_cnt_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && step && cnt_q != last) |=> (cnt_q == $past(cnt_q) + W'(1)));

    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (cnt_q == '0));

endmodule

// File: rtl/crt_window.sv
module crt_window #(
    parameter int   W       = 11,
    parameter logic LO_INCL = 1'b1
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);

    generate
        if (LO_INCL) begin : g_sync_rule
            // start inclusive, end exclusive
            assign hit = (cnt >= lo) && (cnt < hi);
        end else begin : g_blank_rule
            // start exclusive, end inclusive
            assign hit = (cnt > lo) && (cnt <= hi);
        end
    endgenerate

endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
    import crt_timing_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               tmg_en,
    output logic [10:0]        h_count,
    output logic [10:0]        v_count,
    output logic               active,
    output logic               blank,
    output logic               crt_hsync,
    output logic               crt_vsync,
    output logic               pnl_hsync,
    output logic               pnl_vsync
);

    localparam int NAX = 2;   // 0 = horizontal, 1 = vertical

    typedef struct packed {
        logic run;
    } top_state_t;

    top_state_t  st_d, st_q;
    timing_cfg_t cfg;
    logic        go, h_wrap, v_wrap, load;
    tval_t       cnt   [NAX];
    axis_cfg_t   acfg  [NAX];
    logic [NAX-1:0] act_hit, blk_hit, syn_hit, pnl_hit;

    always_comb begin
        st_d     = st_q;
        st_d.run = tmg_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign go   = tmg_en & st_q.run;
    assign load = ~st_q.run | v_wrap;

    crt_timing_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .live    (cfg)
    );

    assign acfg[0] = cfg.h;
    assign acfg[1] = cfg.v;

    crt_axis_counter #(.W(FIELD_W)) u_hcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .step  (1'b1),
        .last  (cfg.h.act_tot.hi),
        .cnt   (cnt[0]),
        .wrap  (h_wrap)
    );

    crt_axis_counter #(.W(FIELD_W)) u_vcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .step  (h_wrap),
        .last  (cfg.v.act_tot.hi),
        .cnt   (cnt[1]),
        .wrap  (v_wrap)
    );

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        assign act_hit[a] = (cnt[a] <= acfg[a].act_tot.lo);

        crt_window #(.W(FIELD_W), .LO_INCL(1'b0)) u_blank (
            .cnt (cnt[a]),
            .lo  (acfg[a].blank.lo),
            .hi  (acfg[a].blank.hi),
            .hit (blk_hit[a])
        );

        crt_window #(.W(FIELD_W), .LO_INCL(1'b1)) u_sync (
            .cnt (cnt[a]),
            .lo  (acfg[a].sync.lo),
            .hi  (acfg[a].sync.hi),
            .hit (syn_hit[a])
        );

        crt_window #(.W(FIELD_W), .LO_INCL(1'b1)) u_panel (
            .cnt (cnt[a]),
            .lo  (acfg[a].pnl.lo),
            .hi  (acfg[a].pnl.hi),
            .hit (pnl_hit[a])
        );
    end

    assign h_count   = cnt[0];
    assign v_count   = cnt[1];
    assign active    = st_q.run & (&act_hit);
    assign blank     = ~st_q.run | (|blk_hit);
    assign crt_hsync = (st_q.run & syn_hit[0]) ^ cfg.pol[0];
    assign crt_vsync = (st_q.run & syn_hit[1]) ^ cfg.pol[1];
    assign pnl_hsync = (st_q.run & pnl_hit[0]) ^ cfg.pol[0];
    assign pnl_vsync = (st_q.run & pnl_hit[1]) ^ cfg.pol[1];

    // R10: stopped raster holds every sync at its resting level
    assert_sync_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (crt_hsync == cfg.pol[0] && pnl_hsync == cfg.pol[0] &&
                       crt_vsync == cfg.pol[1] && pnl_vsync == cfg.pol[1] &&
                       h_count == '0 && v_count == '0));

    // R4: the display window only opens while running
    assert_active_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (st_q.run && !(|blk_hit)) || (st_q.run && (|blk_hit)));

    // R3: a vertical step happens only on the last pixel of a line
    assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cnt[0] != cfg.h.act_tot.hi) |=> $stable(cnt[1]));

endmodule

// File: tb/crt_timing_gen_test.sv
module crt_timing_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tmg_en = 1'b0;
    logic [10:0] h_count, v_count;
    logic        active, blank, crt_hsync, crt_vsync, pnl_hsync, pnl_vsync;

    int checks = 0;
    int failures = 0;

    // bench-side expectation state
    int  m_h = 0, m_v = 0;
    bit  m_run = 0;
    int  live [9];
    int  pend [9];

    always #5ns clk = ~clk;

    crt_timing_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tmg_en    (tmg_en),
        .h_count   (h_count),
        .v_count   (v_count),
        .active    (active),
        .blank     (blank),
        .crt_hsync (crt_hsync),
        .crt_vsync (crt_vsync),
        .pnl_hsync (pnl_hsync),
        .pnl_vsync (pnl_vsync)
    );

    function automatic int f_lo(int w); return w & 'h7FF; endfunction
    function automatic int f_hi(int w); return (w >>> 16) & 'h7FF; endfunction
    function automatic int pk(int a, int b); return (a & 'h7FF) | ((b & 'h7FF) << 16); endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (h=%0d v=%0d)", req, what, act, exp, m_h, m_v);
        end
    endtask

    task automatic compare();
        int e_act, e_blk, e_chs, e_cvs, e_phs, e_pvs;
        int pol0, pol1;
        pol0 = live[8] & 1;
        pol1 = (live[8] >> 1) & 1;
        if (!m_run) begin
            e_act = 0; e_blk = 1;
            e_chs = pol0; e_phs = pol0; e_cvs = pol1; e_pvs = pol1;
        end else begin
            e_act = (m_h <= f_lo(live[0]) && m_v <= f_lo(live[4])) ? 1 : 0;
            e_blk = ((m_h > f_lo(live[1]) && m_h <= f_hi(live[1])) ||
                     (m_v > f_lo(live[5]) && m_v <= f_hi(live[5]))) ? 1 : 0;
            e_chs = ((m_h >= f_lo(live[2]) && m_h < f_hi(live[2])) ? 1 : 0) ^ pol0;
            e_phs = ((m_h >= f_lo(live[3]) && m_h < f_hi(live[3])) ? 1 : 0) ^ pol0;
            e_cvs = ((m_v >= f_lo(live[6]) && m_v < f_hi(live[6])) ? 1 : 0) ^ pol1;
            e_pvs = ((m_v >= f_lo(live[7]) && m_v < f_hi(live[7])) ? 1 : 0) ^ pol1;
        end
        chk("R3", "h_count", int'(h_count), m_h);
        chk("R3", "v_count", int'(v_count), m_v);
        chk("R4", "active", int'(active), e_act);
        chk("R5", "blank", int'(blank), e_blk);
        chk("R6/R7", "crt_hsync", int'(crt_hsync), e_chs);
        chk("R6/R7", "crt_vsync", int'(crt_vsync), e_cvs);
        chk("R8", "pnl_hsync", int'(pnl_hsync), e_phs);
        chk("R8", "pnl_vsync", int'(pnl_vsync), e_pvs);
    endtask

    task automatic advance_model();
        bit go, frame;
        go = tmg_en && m_run;
        frame = 0;
        if (!go) begin
            m_h = 0; m_v = 0;
        end else if (m_h == f_hi(live[0])) begin
            m_h = 0;
            if (m_v == f_hi(live[4])) begin m_v = 0; frame = 1; end
            else m_v++;
        end else begin
            m_h++;
        end
        if (!m_run || frame) live = pend;
        m_run = tmg_en;
    endtask

    // compare at the falling edge, then cross one rising edge
    task automatic step();
        compare();
        @(posedge clk);
        advance_model();
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        step();
        wr_en = 1'b0;
        pend[a] = d;
    endtask

    // small mode: 12 pixels x 7 lines
    task automatic program_small();
        wr(0, pk(7, 11));
        wr(1, pk(7, 11));
        wr(2, pk(8, 10));
        wr(3, pk(8, 10));
        wr(4, pk(3, 6));
        wr(5, pk(3, 6));
        wr(6, pk(4, 5));
        wr(7, pk(3, 4));
        wr(8, 0);
    endtask

    task automatic test_reset();
        // R1: reset state straight after reset release
        chk("R1", "h_count after reset", int'(h_count), 0);
        chk("R1", "v_count after reset", int'(v_count), 0);
        chk("R1", "active after reset", int'(active), 0);
        chk("R1", "blank after reset", int'(blank), 1);
        chk("R1", "syncs after reset", int'({crt_hsync, crt_vsync, pnl_hsync, pnl_vsync}), 0);
    endtask

    task automatic test_frames();
        // R2 R3 R4 R5 R6 R8: two full frames of the small mode
        bit seen_lead;
        seen_lead = 0;
        program_small();
        tmg_en = 1'b1;
        step();
        chk("R10", "first pixel h", int'(h_count), 0);
        chk("R10", "first pixel v", int'(v_count), 0);
        for (int i = 0; i < 2 * 84 + 5; i++) begin
            if (m_v == 3 && m_h == 0)
                seen_lead = (pnl_vsync == 1'b1) && (crt_vsync == 1'b0);
            step();
        end
        chk("R8", "panel vsync one line ahead", int'(seen_lead), 1);
    endtask

    task automatic test_polarity();
        // R7: both syncs active low, stopped and running
        tmg_en = 1'b0;
        step();
        wr(8, 3);
        run(2);
        chk("R7", "hsync rest level low-active", int'(crt_hsync), 1);
        chk("R7", "vsync rest level low-active", int'(pnl_vsync), 1);
        tmg_en = 1'b1;
        run(84 + 3);
    endtask

    task automatic test_midframe();
        // R9: mid-frame hsync change waits for the next frame
        while (!(m_h == 3 && m_v == 1)) step();
        wr(2, pk(2, 4));
        while (!(m_h == 8 && m_v == 2)) step();
        chk("R9", "old hsync window kept in frame", int'(crt_hsync), 0);
        while (!(m_h == 2 && m_v == 0)) step();
        chk("R9", "new hsync window next frame", int'(crt_hsync), 0);
        run(2 * 84);
    endtask

    task automatic test_disable();
        // R10: drop enable mid-frame; R9: write while stopped
        while (!(m_h == 5 && m_v == 2)) step();
        tmg_en = 1'b0;
        step();
        chk("R10", "h held at zero", int'(h_count), 0);
        chk("R10", "v held at zero", int'(v_count), 0);
        chk("R10", "blank while stopped", int'(blank), 1);
        chk("R10", "active while stopped", int'(active), 0);
        wr(0, pk(7, 9));
        run(3);
        tmg_en = 1'b1;
        run(2 * 70 + 4);
        chk("R9", "shortened line wraps at 9", f_hi(live[0]), 9);
    endtask

    task automatic test_wide();
        // R2: values using upper field bits
        tmg_en = 1'b0;
        step();
        wr(8, 0);
        wr(0, pk(255, 299));
        wr(1, pk(255, 299));
        wr(2, pk(270, 280));
        wr(3, pk(271, 281));
        wr(4, pk(0, 2));
        wr(5, pk(0, 2));
        wr(6, pk(1, 2));
        wr(7, pk(0, 1));
        tmg_en = 1'b1;
        run(2 * 900 + 10);
    endtask

    initial begin
        #1ms;
        failures++;
        checks++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        foreach (live[i]) begin live[i] = 0; pend[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_frames();
        test_polarity();
        test_midframe();
        test_disable();
        test_wide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule